// File: doc/BRIEF.md
# GPIO Port Data Register Block

This block is the data side of a 32-pin general-purpose I/O port. Software reaches it through a small 32-bit register bus with single-cycle writes and a combinational read path. The block holds an output value latch and a per-pin direction register. It also presents a synchronised copy of the pin levels for software to read. It drives an output value and an output enable for every pin, and the pad logic outside the block uses them.

Three write-only alias registers give software a way to change chosen output bits without a read-modify-write sequence. A one written to the set alias forces that latch bit high, a one written to the clear alias forces it low, and a one written to the toggle alias inverts it. Zero bits in these writes leave the latch unchanged. Two code paths can therefore drive different pins of the same port without a lock.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is high and on the first cycle after it, the output latch and the direction register are zero, so every pin_oe bit and every pin_out bit is 0 and the input register reads 0.
- R2: A write to byte address 0x00 replaces the whole output latch with bus_wdata at the clock edge. A read of 0x00 returns the latch.
- R3: A write to 0x04 sets every latch bit whose bus_wdata bit is 1 and leaves the other latch bits unchanged.
- R4: A write to 0x08 clears every latch bit whose bus_wdata bit is 1 and leaves the other latch bits unchanged.
- R5: A write to 0x0C inverts every latch bit whose bus_wdata bit is 1 and leaves the other latch bits unchanged.
- R6: Reads of 0x04, 0x08 and 0x0C return zero.
- R7: A read of 0x10 returns pin_in as it was two clock edges earlier, through a two-flop synchroniser. This register is read-only, and a write to 0x10 changes neither the latch nor the direction register.
- R8: A write to 0x14 replaces the direction register, and a read of 0x14 returns it. pin_oe always equals the direction register, where 1 means output. pin_out always equals the output latch, whatever the direction bits are.
- R9: Every other address reads 0, and a write to it has no effect. This covers 0x18, 0x1C and any address whose two low bits are not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle, taken at the clock edge |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |

## Verification
Assertions check on every cycle that the set, clear and toggle aliases act on the latch as written. They also check the reset values, that writes to the input, direction and unmapped addresses leave the pin outputs alone, that the alias addresses read zero, that the direction readback matches pin_oe, and that the input register trails pin_in by two edges. The bench scenarios cover the rest: full overwrite of the latch, combined sequences of alias writes, readback after a write to the read-only register, misaligned addresses, and a reset in the middle of a run with the latch and direction register non-zero. These scenarios are compared against a behavioural model on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_SET  = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_TGL  = 3'd3,
        SEL_IN   = 3'd4,
        SEL_DIR  = 3'd5,
        SEL_RSV6 = 3'd6,
        SEL_RSV7 = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic wr_data;
        logic wr_set;
        logic wr_clr;
        logic wr_tgl;
        logic wr_dir;
    } wr_strobe_t;

    // Word index from byte address; misaligned addresses map to a reserved slot.
    function automatic reg_sel_e addr_to_sel(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return SEL_RSV7;
        return reg_sel_e'(a[4:2]);
    endfunction

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_port_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel,
    output wr_strobe_t    strb
);
    always_comb begin
        sel          = addr_to_sel(addr);
        strb         = '0;
        strb.wr_data = wr && (sel == SEL_DATA);
        strb.wr_set  = wr && (sel == SEL_SET);
        strb.wr_clr  = wr && (sel == SEL_CLR);
        strb.wr_tgl  = wr && (sel == SEL_TGL);
        strb.wr_dir  = wr && (sel == SEL_DIR);
    end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_strobe_t   strb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic nxt;
            always_comb begin
                nxt = out_q[i];
                if (strb.wr_data)               nxt = wdata[i];
                else if (strb.wr_set && wdata[i]) nxt = 1'b1;
                else if (strb.wr_clr && wdata[i]) nxt = 1'b0;
                else if (strb.wr_tgl && wdata[i]) nxt = ~out_q[i];
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q[i] <= 1'b0;
                    dir_q[i] <= 1'b0;
                end else begin
                    out_q[i] <= nxt;
                    if (strb.wr_dir) dir_q[i] <= wdata[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = gpio_port_pkg::PORT_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PORT_W_P = PORT_W,
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W_P-1:0] bus_addr,
    input  logic [PORT_W_P-1:0] bus_wdata,
    output logic [PORT_W_P-1:0] bus_rdata,
    input  logic [PORT_W_P-1:0] pin_in,
    output logic [PORT_W_P-1:0] pin_out,
    output logic [PORT_W_P-1:0] pin_oe
);
    reg_sel_e              sel;
    wr_strobe_t            strb;
    logic [PORT_W_P-1:0]   out_q;
    logic [PORT_W_P-1:0]   dir_q;
    logic [PORT_W_P-1:0]   in_sync;

    gpio_reg_decode #(.AW(ADDR_W_P)) u_dec (
        .wr   (bus_wr),
        .addr (bus_addr),
        .sel  (sel),
        .strb (strb)
    );

    gpio_out_latch #(.W(PORT_W_P)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .strb  (strb),
        .wdata (bus_wdata),
        .out_q (out_q),
        .dir_q (dir_q)
    );

    gpio_in_sync #(.W(PORT_W_P), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    always_comb begin
        unique case (sel)
            SEL_DATA: bus_rdata = out_q;
            SEL_IN:   bus_rdata = in_sync;
            SEL_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  pin_in,
    input logic [W-1:0]  pin_out,
    input logic [W-1:0]  pin_oe
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0));

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h04) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

    assert_clear_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h08) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

    assert_toggle_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h0C) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

    assert_alias_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 5'h04 || bus_addr == 5'h08 || bus_addr == 5'h0C) |-> bus_rdata == '0);

    assert_input_delay_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && bus_addr == 5'h10) |-> bus_rdata == $past(pin_in, 2));

    assert_input_wr_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h10) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_dir_readback_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 5'h14) |-> bus_rdata == pin_oe);

    assert_dir_wr_keeps_out_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h14) |=> $stable(pin_out));

    assert_unmapped_wr_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr[1:0] != 2'b00 || bus_addr[4:3] == 2'b11))
        |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.W(PORT_W_P), .AW(ADDR_W_P)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural model state
    logic [31:0] m_out = '0;
    logic [31:0] m_dir = '0;
    logic [31:0] m_pin_hist [$];

    gpio_port_regs uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return '0;
        case (a)
            5'h00: return m_out;
            5'h10: return m_pin_hist.size() >= 2 ? m_pin_hist[m_pin_hist.size()-2] : 32'h0;
            5'h14: return m_dir;
            default: return '0;
        endcase
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_out = '0;
            m_dir = '0;
            m_pin_hist.delete();
            m_pin_hist.push_back('0);
            m_pin_hist.push_back('0);
        end else begin
            m_pin_hist.push_back(pin_in);
            if (m_pin_hist.size() > 4) void'(m_pin_hist.pop_front());
            if (bus_wr) begin
                case (bus_addr)
                    5'h00: m_out = bus_wdata;
                    5'h04: m_out = m_out | bus_wdata;
                    5'h08: m_out = m_out & ~bus_wdata;
                    5'h0C: m_out = m_out ^ bus_wdata;
                    5'h14: m_dir = bus_wdata;
                    default: ;
                endcase
            end
        end
    endtask

    // drive one cycle, compare outputs against the model, then advance
    task automatic step(input bit w, input logic [4:0] a, input logic [31:0] d,
                        input logic [31:0] p, input bit r, input string tag);
        @(negedge clk);
        rst = r; bus_wr = w; bus_addr = a; bus_wdata = d; pin_in = p;
        #1;
        check(tag, "rdata", bus_rdata, model_read(a));
        check(tag, "pin_out (R8)", pin_out, m_out);
        check(tag, "pin_oe (R8)", pin_oe, m_dir);
        @(posedge clk);
        model_edge();
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state
        step(0, 5'h10, '0, 32'hFFFF_FFFF, 1, "R1");
        step(0, 5'h00, '0, 32'hFFFF_FFFF, 1, "R1");
        step(0, 5'h10, '0, 32'h1357_9BDF, 0, "R1");
        step(0, 5'h14, '0, 32'h1357_9BDF, 0, "R1");

        // R2: full overwrite and readback
        step(1, 5'h00, 32'hA5A5_0F0F, 32'h0, 0, "R2");
        step(0, 5'h00, '0, 32'h0, 0, "R2");
        step(1, 5'h00, 32'h3C3C_C3C3, 32'h0, 0, "R2");
        step(0, 5'h00, '0, 32'h0, 0, "R2");

        // R3: set alias, then read it back as zero (R6)
        step(1, 5'h04, 32'h0000_F0F0, 32'h0, 0, "R3");
        step(0, 5'h04, '0, 32'h0, 0, "R6");
        step(1, 5'h04, 32'h0000_0000, 32'h0, 0, "R3");
        step(0, 5'h00, '0, 32'h0, 0, "R3");

        // R4: clear alias
        step(1, 5'h08, 32'hA000_0001, 32'h0, 0, "R4");
        step(0, 5'h08, '0, 32'h0, 0, "R6");
        step(0, 5'h00, '0, 32'h0, 0, "R4");

        // R5: toggle alias twice restores
        step(1, 5'h0C, 32'hFFFF_0000, 32'h0, 0, "R5");
        step(0, 5'h0C, '0, 32'h0, 0, "R6");
        step(1, 5'h0C, 32'hFFFF_0000, 32'h0, 0, "R5");
        step(1, 5'h0C, 32'h8000_0001, 32'h0, 0, "R5");
        step(0, 5'h00, '0, 32'h0, 0, "R5");

        // R8: direction register
        step(1, 5'h14, 32'h0F0F_00FF, 32'h0, 0, "R8");
        step(0, 5'h14, '0, 32'h0, 0, "R8");
        step(1, 5'h14, 32'hFFFF_FFFF, 32'h0, 0, "R8");
        step(1, 5'h14, 32'h0000_0000, 32'h0, 0, "R8");

        // R7: synchroniser delay and read-only behaviour
        step(0, 5'h10, '0, 32'hDEAD_BEEF, 0, "R7");
        step(0, 5'h10, '0, 32'h0123_4567, 0, "R7");
        step(0, 5'h10, '0, 32'hFFFF_0000, 0, "R7");
        step(0, 5'h10, '0, 32'h0000_FFFF, 0, "R7");
        step(1, 5'h10, 32'h1234_5678, 32'h0000_FFFF, 0, "R7");
        step(0, 5'h00, '0, 32'h0000_FFFF, 0, "R7");
        step(0, 5'h10, '0, 32'h0000_FFFF, 0, "R7");

        // R9: unmapped and misaligned addresses
        step(1, 5'h18, 32'hFFFF_FFFF, 32'h0, 0, "R9");
        step(0, 5'h18, '0, 32'h0, 0, "R9");
        step(1, 5'h1C, 32'hFFFF_FFFF, 32'h0, 0, "R9");
        step(0, 5'h1C, '0, 32'h0, 0, "R9");
        step(1, 5'h01, 32'hFFFF_FFFF, 32'h0, 0, "R9");
        step(1, 5'h16, 32'hFFFF_FFFF, 32'h0, 0, "R9");
        step(0, 5'h11, '0, 32'h0, 0, "R9");
        step(0, 5'h00, '0, 32'h0, 0, "R9");

        // R1: reset mid-run with non-zero state
        step(1, 5'h14, 32'hCAFE_F00D, 32'h5555_AAAA, 0, "R8");
        step(1, 5'h00, 32'h1111_2222, 32'h5555_AAAA, 0, "R2");
        step(0, 5'h00, '0, 32'h5555_AAAA, 0, "R2");
        step(0, 5'h00, '0, 32'h5555_AAAA, 1, "R1");
        step(0, 5'h10, '0, 32'h5555_AAAA, 0, "R1");
        step(0, 5'h14, '0, 32'h5555_AAAA, 0, "R1");
        step(0, 5'h10, '0, 32'h5555_AAAA, 0, "R7");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule